// File: doc/BRIEF.md
# I2C Slave Receive Engine with Two-Stage Receive Buffer

This block is the receive half of an I2C target. It watches SCL and SDA, which must already be synchronous to the system clock. It recognises start and stop conditions and compares the address sent after each start with an own address that software can program. When the address matches and the direction bit asks for a write to the target, the block shifts in data bytes MSB first. On the ninth clock of each frame it answers with an acknowledge level chosen by software. It drives the bus only through an open-drain enable, `sda_oe_o`, which pulls SDA low when high.

Each finished byte moves from the shift register into a holding register and raises a buffer-full flag and a sticky interrupt flag. If the holding register is still full when another byte completes, that byte waits in a staging register. The CPU's read of the holding register then moves it forward and raises both flags again. A stop condition clears the bus-busy flag, sets a stop flag and, unless masked, raises the interrupt flag. A four-word register port gives the CPU control, status, data and own-address access.

Register word offsets: 0 = control (bit 0 acknowledge level, 1 = NACK; bit 1 stop-interrupt mask; bit 2 interrupt enable); 1 = status (bit 0 busy, bit 1 stop, bit 2 full, bit 3 interrupt); 2 = received data (read only); 3 = own address in bits 6:0.

Top module: `i2c_slave_rx`

## Requirements
- R1: SDA falling while SCL is high is a start condition; it sets the busy flag (status bit 0) to 1.
- R2: The first frame after a start carries a 7-bit address MSB first, then a direction bit; the block is selected only if the address equals the own address (offset 3, bits 6:0) and the direction bit is 0.
- R3: After an address that does not match, or a direction bit of 1, the block never drives SDA and sets no full or interrupt flag until the next start condition.
- R4: In the ninth clock of every selected frame (address and data) the block pulls SDA low when control bit 0 is 0 and leaves it released when that bit is 1. `sda_oe_o` changes only while SCL is low and is released after the ninth falling edge.
- R5: Data bits are taken MSB first on SCL rising edges. At the ninth rising edge of a data frame the byte moves into the holding register (read at offset 2) and the full flag (status bit 2) is set.
- R6: The interrupt flag (status bit 3) is set at the ninth rising edge of a data frame, and `irq_o` equals that flag ANDed with control bit 2.
- R7: A read at offset 2 with no byte waiting in the staging register clears the full flag.
- R8: A byte completed while the full flag is 1 is kept. The next read at offset 2 returns the older byte, loads the kept byte into the holding register and sets both the full and interrupt flags to 1.
- R9: SDA rising while SCL is high is a stop condition. It clears busy and sets the stop flag (status bit 1). It sets the interrupt flag only when control bit 1 is 0.
- R10: The stop and interrupt flags are cleared only by a status write with that bit at 0; writing 1 to either bit leaves it unchanged.
- R11: A start condition in the middle of a frame (a repeated start) discards the partial frame and starts a new address phase.
- R12: After reset, the control register and all status flags are 0, the own address equals the `OWN_RST` parameter, and `sda_oe_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock level, already synchronous to clk_i |
| sda_i | input | 1 | Bus data level, already synchronous to clk_i |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_wr_i | input | 1 | Register write strobe, one cycle |
| reg_rd_i | input | 1 | Register read strobe, one cycle (side effect on offset 2) |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | ADDR_W+1 | Register write data |
| reg_rdata_o | output | ADDR_W+1 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Interrupt request: interrupt flag and enable |

## Verification
The bench builds the block with `OWN_RST` set to 0x2C, not the default, and with a three-stage reset synchronizer. This lets the first transfer after reset match on the reset own address with no programming. Later transfers run after the own address is rewritten to 0x13, so both the reset value and the write path of the comparator are tested. The default 7-bit address width gives 8-bit frames. Random bursts then mix matching and foreign addresses, both direction bits and both acknowledge levels, with directed cases for the two-byte pending refill, masked and unmasked stops, and a repeated start mid-byte.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

  // register word offsets
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_STAT = 2'd1;
  localparam logic [1:0] OFF_DATA = 2'd2;
  localparam logic [1:0] OFF_OWN  = 2'd3;

  // control bit positions
  localparam int unsigned CTRL_NACK  = 0;
  localparam int unsigned CTRL_SMASK = 1;
  localparam int unsigned CTRL_IEN   = 2;
  localparam int unsigned CTRL_W     = 3;

  // status bit positions
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_STOP = 1;
  localparam int unsigned ST_FULL = 2;
  localparam int unsigned ST_IRQ  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

endpackage

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_q, scl_n;
  logic sda_q, sda_n;

  always_comb begin
    scl_n = scl_i;
    sda_n = sda_i;
  end

  // previous levels reset to an idle bus so release creates no event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  always_comb begin
    start_o = scl_q & scl_i & sda_q & ~sda_i;
    stop_o  = scl_q & scl_i & ~sda_q & sda_i;
    rise_o  = ~scl_q & scl_i;
    fall_o  = scl_q & ~scl_i;
  end

  // an SCL edge and a bus condition never coincide
  a_r9_cond_not_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(rise_o || fall_o));

endmodule

// File: rtl/i2c_srx_frame.sv
module i2c_srx_frame
  import i2c_srx_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              nack_i,
  output logic              byte_done_o,
  output logic [ADDR_W:0]   byte_o,
  output logic              sda_oe_o
);

  localparam int unsigned DATA_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(DATA_W + 1);

  phase_e             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [DATA_W-1:0]  shift_q, shift_n;
  logic               drive_q, drive_n;
  logic               shift_en;
  logic               addr_hit;

  assign addr_hit = (shift_q[DATA_W-1:1] == own_addr_i) && !shift_q[0];

  always_comb begin
    phase_n     = phase_q;
    cnt_n       = cnt_q;
    drive_n     = drive_q;
    shift_en    = 1'b0;
    byte_done_o = 1'b0;
    if (start_i) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
      drive_n = 1'b0;
    end else if (stop_i) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      drive_n = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (rise_i) begin
        if (cnt_q < ACK_CNT) begin
          shift_en = 1'b1;
        end else if (phase_q == PH_DATA) begin
          byte_done_o = 1'b1;
        end
        cnt_n = cnt_q + 1'b1;
      end else if (fall_i) begin
        if (cnt_q == ACK_CNT) begin
          if (phase_q == PH_DATA || addr_hit) begin
            drive_n = ~nack_i;
          end else begin
            phase_n = PH_IDLE;
          end
        end else if (cnt_q == END_CNT) begin
          drive_n = 1'b0;
          cnt_n   = '0;
          if (phase_q == PH_ADDR) begin
            phase_n = PH_DATA;
          end
        end
      end
    end
    shift_n = shift_en ? {shift_q[DATA_W-2:0], sda_i} : shift_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      drive_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      shift_q <= shift_n;
      drive_q <= drive_n;
    end
  end

  assign byte_o   = shift_q;
  assign sda_oe_o = drive_q;

  // R4: the drive only toggles while the bus clock was low
  a_r4_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drive_q) |-> !$past(scl_i));

  // R3: an unselected or idle engine keeps SDA released
  a_r3_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> !drive_q);

  // R11: any start re-arms the address phase from bit zero
  a_r11_start_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase_q == PH_ADDR) && (cnt_q == '0) && !drive_q);

endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
  import i2c_srx_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter logic [ADDR_W-1:0] OWN_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [ADDR_W:0]   wdata_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic [ADDR_W:0]   byte_i,
  output logic [ADDR_W:0]   rdata_o,
  output logic              nack_o,
  output logic [ADDR_W-1:0] own_o,
  output logic              irq_o
);

  localparam int unsigned DATA_W = ADDR_W + 1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [ADDR_W-1:0] own_q, own_n;
  logic              busy_q, busy_n;
  logic              stop_q, stop_n;
  logic              full_q, full_n;
  logic              irq_q, irq_n;
  logic              pend_q, pend_n;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic [DATA_W-1:0] stage_q, stage_n;
  logic              rd_data;
  logic              wr_stat;
  logic              unused_wdata_msb;

  assign rd_data          = rd_i && (addr_i == OFF_DATA);
  assign wr_stat          = wr_i && (addr_i == OFF_STAT);
  assign unused_wdata_msb = wdata_i[DATA_W-1];

  always_comb begin
    ctrl_n  = ctrl_q;
    own_n   = own_q;
    busy_n  = busy_q;
    stop_n  = stop_q;
    full_n  = full_q;
    irq_n   = irq_q;
    pend_n  = pend_q;
    hold_n  = hold_q;
    stage_n = stage_q;

    // software writes: flags are clear-only
    if (wr_i) begin
      case (addr_i)
        OFF_CTRL: ctrl_n = wdata_i[CTRL_W-1:0];
        OFF_OWN:  own_n  = wdata_i[ADDR_W-1:0];
        OFF_STAT: begin
          if (!wdata_i[ST_STOP]) stop_n = 1'b0;
          if (!wdata_i[ST_IRQ])  irq_n  = 1'b0;
        end
        default: ;
      endcase
    end

    // data read: drain or refill from the staging register
    if (rd_data) begin
      if (pend_q) begin
        hold_n = stage_q;
        full_n = 1'b1;
        irq_n  = 1'b1;
        pend_n = 1'b0;
      end else begin
        full_n = 1'b0;
      end
    end

    // bus events take priority over software clears
    if (byte_done_i) begin
      if (!full_n) begin
        hold_n = byte_i;
        full_n = 1'b1;
        irq_n  = 1'b1;
      end else begin
        stage_n = byte_i;
        pend_n  = 1'b1;
      end
    end
    if (start_i) begin
      busy_n = 1'b1;
    end
    if (stop_i) begin
      busy_n = 1'b0;
      stop_n = 1'b1;
      if (!ctrl_q[CTRL_SMASK]) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      own_q   <= OWN_RST;
      busy_q  <= 1'b0;
      stop_q  <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
      stage_q <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      own_q   <= own_n;
      busy_q  <= busy_n;
      stop_q  <= stop_n;
      full_q  <= full_n;
      irq_q   <= irq_n;
      pend_q  <= pend_n;
      hold_q  <= hold_n;
      stage_q <= stage_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      OFF_STAT: begin
        rdata_o[ST_BUSY] = busy_q;
        rdata_o[ST_STOP] = stop_q;
        rdata_o[ST_FULL] = full_q;
        rdata_o[ST_IRQ]  = irq_q;
      end
      OFF_DATA: rdata_o = hold_q;
      default:  rdata_o[ADDR_W-1:0] = own_q;
    endcase
  end

  assign nack_o = ctrl_q[CTRL_NACK];
  assign own_o  = own_q;
  assign irq_o  = irq_q & ctrl_q[CTRL_IEN];

  // R1: a start leaves the bus marked busy
  a_r1_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);

  // R9: a stop clears busy and records itself
  a_r9_stop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_q && stop_q);

  // R9: a masked stop on its own raises no interrupt
  a_r9_masked_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && ctrl_q[CTRL_SMASK] && !irq_q && !byte_done_i && !rd_data && !wr_i
    |=> !irq_q);

  // R7: draining with nothing staged empties the buffer
  a_r7_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && !pend_q && !byte_done_i |=> !full_q);

  // R8: draining with a staged byte refills and re-flags
  a_r8_read_refills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && pend_q |=> full_q && irq_q);

  // R10: the interrupt flag only falls on a clearing write
  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !(wr_stat && !wdata_i[ST_IRQ]) |=> irq_q);

  // R10: same for the stop flag
  a_r10_stop_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !(wr_stat && !wdata_i[ST_STOP]) |=> stop_q);

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] OWN_RST  = 7'h50,
  parameter int unsigned       RST_SYNC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [ADDR_W:0] reg_wdata_i,
  output logic [ADDR_W:0] reg_rdata_o,
  output logic            irq_o
);

  localparam int unsigned SYNC_W = (RST_SYNC < 2) ? 2 : RST_SYNC;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  logic              start_w, stop_w, rise_w, fall_w;
  logic              byte_done_w;
  logic [ADDR_W:0]   byte_w;
  logic              nack_w;
  logic [ADDR_W-1:0] own_w;

  i2c_srx_cond u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2c_srx_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .sda_i       (sda_i),
    .scl_i       (scl_i),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .own_addr_i  (own_w),
    .nack_i      (nack_w),
    .byte_done_o (byte_done_w),
    .byte_o      (byte_w),
    .sda_oe_o    (sda_oe_o)
  );

  i2c_srx_regs #(.ADDR_W(ADDR_W), .OWN_RST(OWN_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .byte_done_i (byte_done_w),
    .byte_i      (byte_w),
    .rdata_o     (reg_rdata_o),
    .nack_o      (nack_w),
    .own_o       (own_w),
    .irq_o       (irq_o)
  );

  // R6: no request while the block is held in reset
  a_r6_irq_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_int_n |-> !irq_o);

endmodule

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;

  localparam int H = 8;
  localparam logic [6:0] RST_OWN = 7'h2C;
  localparam logic [6:0] NEW_OWN = 7'h13;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_OWN = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m;
  logic sda_oe;
  logic wr, rd;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic irq;
  wire  sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_slave_rx #(.ADDR_W(7), .OWN_RST(RST_OWN), .RST_SYNC(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] st(bit busy, bit stp, bit full, bit ir);
    return {4'b0, ir, full, stp, busy};
  endfunction

  function automatic bit exp_sel(logic [6:0] a, logic [6:0] own, bit rw);
    return (a == own) && !rw;
  endfunction

  function automatic bit exp_ack_line(bit sel, bit nack);
    return sel ? nack : 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic expect_reg(logic [1:0] a, logic [7:0] exp, string req);
    logic [7:0] v;
    cpu_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic bus_start;
    hw(H/2); sda_m = 1'b1; hw(H/2);
    scl = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    hw(H/2); sda_m = 1'b0; hw(H/2);
    scl = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic bus_bit(bit b, output bit seen);
    hw(H/2); sda_m = b; hw(H/2);
    scl = 1'b1; hw(H/2);
    seen = sda_line; hw(H/2);
    scl = 1'b0;
  endtask

  task automatic bus_byte(logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, ack);
    hw(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d, d1, d2, v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    hw(5); rst_n = 1'b1; hw(6);

    // R12 reset state
    expect_reg(A_STAT, 8'h00, "R12 status");
    expect_reg(A_CTRL, 8'h00, "R12 ctrl");
    expect_reg(A_OWN, {1'b0, RST_OWN}, "R12 own");
    chk("R12 sda_oe", sda_oe, 0);
    chk("R12 irq", irq, 0);

    cpu_wr(A_CTRL, 8'h04);
    bus_start; hw(2);
    expect_reg(A_STAT, st(1, 0, 0, 0), "R1 busy after start");
    bus_byte({RST_OWN, 1'b0}, ack);
    chk("R2 address ack", ack, 0);

    d = 8'($urandom);
    bus_byte(d, ack);
    chk("R4 data ack", ack, 0);
    chk("R4 released after ninth", sda_oe, 0);
    expect_reg(A_STAT, st(1, 0, 1, 1), "R5 R6 flags");
    chk("R6 irq out", irq, 1);
    expect_reg(A_DATA, d, "R5 data");
    expect_reg(A_STAT, st(1, 0, 0, 1), "R7 full cleared");
    cpu_wr(A_STAT, 8'h0A);
    expect_reg(A_STAT, st(1, 0, 0, 1), "R10 write one keeps");
    cpu_wr(A_STAT, 8'h00);
    expect_reg(A_STAT, st(1, 0, 0, 0), "R10 write zero clears");
    chk("R6 irq out low", irq, 0);

    // R8 pending byte
    d1 = 8'($urandom); d2 = 8'($urandom);
    bus_byte(d1, ack);
    bus_byte(d2, ack);
    chk("R8 second ack", ack, 0);
    cpu_wr(A_STAT, 8'h00);
    expect_reg(A_DATA, d1, "R8 first byte");
    expect_reg(A_STAT, st(1, 0, 1, 1), "R8 refill flags");
    expect_reg(A_DATA, d2, "R8 second byte");
    expect_reg(A_STAT, st(1, 0, 0, 1), "R7 drained");
    cpu_wr(A_STAT, 8'h00);

    // R4 NACK
    cpu_wr(A_CTRL, 8'h05);
    bus_byte(8'h5A, ack);
    chk("R4 nack level", ack, 1);
    expect_reg(A_DATA, 8'h5A, "R5 data under nack");
    cpu_wr(A_STAT, 8'h00);
    cpu_wr(A_CTRL, 8'h04);

    // R9 unmasked stop
    bus_stop; hw(2);
    expect_reg(A_STAT, st(0, 1, 0, 1), "R9 unmasked stop");
    cpu_wr(A_STAT, 8'h00);
    expect_reg(A_STAT, 8'h00, "R10 stop cleared");

    // R9 masked stop
    cpu_wr(A_CTRL, 8'h06);
    bus_start;
    bus_byte({RST_OWN, 1'b0}, ack);
    bus_byte(8'hC3, ack);
    cpu_rd(A_DATA, v);
    cpu_wr(A_STAT, 8'h00);
    bus_stop; hw(2);
    expect_reg(A_STAT, st(0, 1, 0, 0), "R9 masked stop");
    chk("R9 masked irq", irq, 0);
    cpu_wr(A_STAT, 8'h00);
    cpu_wr(A_CTRL, 8'h04);

    cpu_wr(A_OWN, {1'b0, NEW_OWN});
    expect_reg(A_OWN, {1'b0, NEW_OWN}, "R2 own write");

    // R3 foreign address
    bus_start;
    bus_byte({RST_OWN, 1'b0}, ack);
    chk("R3 foreign addr nack", ack, 1);
    bus_byte(8'h00, ack);
    chk("R3 foreign data nack", ack, 1);
    expect_reg(A_STAT, st(1, 0, 0, 0), "R3 no flags");
    // R2 direction bit 1
    bus_start;
    bus_byte({NEW_OWN, 1'b1}, ack);
    chk("R2 read dir ignored", ack, 1);
    bus_byte(8'h00, ack);
    chk("R3 after read dir", ack, 1);
    expect_reg(A_STAT, st(1, 0, 0, 0), "R3 no flags read dir");

    // R11 repeated start mid-byte
    bus_start;
    bus_byte({NEW_OWN, 1'b0}, ack);
    for (int i = 0; i < 4; i++) begin bit s; bus_bit(1'b0, s); end
    bus_start;
    bus_byte({NEW_OWN, 1'b0}, ack);
    chk("R11 address after restart", ack, 0);
    bus_byte(8'hA7, ack);
    expect_reg(A_DATA, 8'hA7, "R11 data after restart");
    cpu_wr(A_STAT, 8'h00);
    bus_stop;
    cpu_wr(A_STAT, 8'h00);

    // random traffic
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      bit rw, nk, sel;
      int nb;
      a  = ($urandom % 4 != 0) ? NEW_OWN : 7'($urandom);
      rw = ($urandom % 5 == 0);
      nk = ($urandom % 3 == 0);
      nb = 1 + ($urandom % 3);
      sel = exp_sel(a, NEW_OWN, rw);
      cpu_wr(A_CTRL, {5'b0, 1'b1, 1'b0, nk});
      bus_start;
      bus_byte({a, rw}, ack);
      chk("R2 random address ack", ack, exp_ack_line(sel, nk));
      for (int k = 0; k < nb; k++) begin
        d = 8'($urandom);
        bus_byte(d, ack);
        chk("R4 random data ack", ack, exp_ack_line(sel, nk));
        if (sel) begin
          expect_reg(A_DATA, d, "R5 random data");
          cpu_wr(A_STAT, 8'h00);
        end else begin
          expect_reg(A_STAT, st(1, 0, 0, 0), "R3 random ignored");
        end
      end
      bus_stop; hw(2);
      expect_reg(A_STAT, st(0, 1, 0, 1), "R9 random stop");
      cpu_wr(A_STAT, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule